// File: doc/BRIEF.md
# Branch-Steering Instruction Fetch Front End

This block is the front end of a small in-order pipeline. It owns the program counter, drives the instruction-memory address, and registers each fetched word together with its incremented address into a fetch-to-decode stage. A partial decode of that stage spots branch words and computes their relative targets. It applies a static direction guess: a conditional branch that jumps backward is treated as a loop and followed at once, and one that jumps forward falls through. An unconditional branch is always followed from decode.

The decoded branch, its guessed direction, its target and its fall-through address move into an execute-stage register that the rest of the pipeline sees. The condition unit outside the block returns the real outcome on `ex_cond_taken`. When the outcome disagrees with the guess, the block kills both younger slots and restarts fetch on the correct path in the next cycle. Killed slots become bubbles with their valid bit cleared.

Top module: `bfe_frontend`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `imem_addr` is 0. During reset `id_valid`, `ex_valid` and `ex_mispredict` are 0.
- R2: With no redirect, `imem_addr` advances by 4 every cycle. One cycle after a word is fetched, `id_instr` holds that word and `id_npc` holds its address plus 4.
- R3: A branch target is `npc + (sign-extended instr[15:0] << 2)`, with wrap-around at the address width. The branch's `npc` and target appear on `ex_npc` and `ex_target` while it is in the execute stage.
- R4: The word is a branch when bit 31 is 1. Bit 30 then selects unconditional (1) or conditional (0). A word with bit 31 at 0 is never redirected.
- R5: A conditional branch with offset bit 15 at 1 is predicted taken. In the cycle after it sits in decode, `imem_addr` is its target and `id_valid` is 0, because the fall-through word is squashed.
- R6: A conditional branch with offset bit 15 at 0 is predicted not taken. Fetch continues at the sequential address with no bubble.
- R7: An unconditional branch redirects fetch from decode, whatever its offset sign. It is never reported as mispredicted, whatever `ex_cond_taken` says.
- R8: `ex_mispredict` is 1 in the cycle a conditional branch sits in execute with `ex_cond_taken` different from its prediction. In the next cycle `id_valid` and `ex_valid` are 0, and `imem_addr` is the target if the branch was taken or its `npc` if it was not.
- R9: A correctly predicted conditional branch raises no `ex_mispredict` and causes no extra flush.
- R10: When an execute-stage restart and a decode-stage redirect fall in the same cycle, the execute-stage address wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | AW | Fetch address (current PC) |
| imem_rdata | input | IW | Instruction word at `imem_addr`, same cycle |
| ex_cond_taken | input | 1 | Real condition outcome of the branch now in execute |
| id_valid | output | 1 | Decode slot holds a live instruction |
| id_instr | output | IW | Decode-slot instruction word |
| id_npc | output | AW | Decode-slot incremented address |
| ex_valid | output | 1 | Execute slot holds a live instruction |
| ex_instr | output | IW | Execute-slot instruction word |
| ex_npc | output | AW | Execute-slot incremented address |
| ex_target | output | AW | Execute-slot relative branch target |
| ex_is_cond | output | 1 | Execute slot is a conditional branch |
| ex_pred_taken | output | 1 | Direction guessed in decode |
| ex_mispredict | output | 1 | Guess disagreed with `ex_cond_taken` |

## Verification
The bench places one branch, and sometimes a second one right behind it, at a fixed address. It then follows the fetch address for three cycles across every mix of direction, sign and real outcome. This exposes a design that guesses from the wrong bit, omits the one-cycle bubble, or restarts at the target instead of the fall-through address after a wrongly taken loop guess. Extreme offsets (most negative, most positive) catch missing sign extension or shift. A forward branch that really jumps, followed by an unconditional branch, catches a design that lets the decode redirect override the execute restart. An unconditional branch paired with a false condition outcome catches a design that tries to correct branches that cannot be wrong.

// File: rtl/bfe_pkg.sv
package bfe_pkg;
    // Source chosen for the next fetch address, in priority order.
    typedef enum logic [1:0] {
        SRC_SEQ   = 2'd0,
        SRC_ID    = 2'd1,
        SRC_EX    = 2'd2
    } pc_src_e;

    localparam int unsigned INSTR_BYTES = 4;
    localparam int unsigned WORD_SHIFT  = 2;
endpackage

// File: rtl/bfe_predecode.sv
module bfe_predecode #(
    parameter int unsigned AW   = 32,
    parameter int unsigned OFFW = 16
) (
    input  logic            slot_valid,
    input  logic            br_flag,
    input  logic            unc_flag,
    input  logic [OFFW-1:0] offset,
    input  logic [AW-1:0]   npc,
    output logic            is_cond,
    output logic            redirect,
    output logic [AW-1:0]   target
);
    import bfe_pkg::*;

    localparam int unsigned EXT_W = AW - OFFW - WORD_SHIFT;

    logic [AW-1:0] disp;
    logic          backward;
    logic          is_br;

    generate
        if (EXT_W > 0) begin : g_ext
            assign disp = {{EXT_W{offset[OFFW-1]}}, offset, {WORD_SHIFT{1'b0}}};
        end else begin : g_trunc
            assign disp = AW'({offset, {WORD_SHIFT{1'b0}}});
        end
    endgenerate

    always_comb begin
        is_br    = slot_valid && br_flag;
        backward = offset[OFFW-1];
        is_cond  = is_br && !unc_flag;
        target   = npc + disp;
        // follow unconditional branches and backward conditional ones
        redirect = is_br && (unc_flag || backward);
    end
endmodule

// File: rtl/bfe_resolve.sv
module bfe_resolve #(
    parameter int unsigned AW = 32
) (
    input  logic          slot_valid,
    input  logic          is_cond,
    input  logic          pred_taken,
    input  logic          cond_taken,
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] npc,
    output logic          mispredict,
    output logic [AW-1:0] fix_pc
);
    always_comb begin
        mispredict = slot_valid && is_cond && (pred_taken != cond_taken);
        fix_pc     = cond_taken ? target : npc;
    end
endmodule

// File: rtl/bfe_pcsel.sv
module bfe_pcsel #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] seq_pc,
    input  logic          id_redirect,
    input  logic [AW-1:0] id_target,
    input  logic          ex_restart,
    input  logic [AW-1:0] ex_pc,
    output logic [AW-1:0] pc_next,
    output logic          kill_if,
    output logic          kill_id
);
    import bfe_pkg::*;

    pc_src_e src;

    always_comb begin
        if (ex_restart)       src = SRC_EX;
        else if (id_redirect) src = SRC_ID;
        else                  src = SRC_SEQ;

        unique case (src)
            SRC_EX:  pc_next = ex_pc;
            SRC_ID:  pc_next = id_target;
            default: pc_next = seq_pc;
        endcase

        kill_if = (src != SRC_SEQ);
        kill_id = (src == SRC_EX);
    end
endmodule

// File: rtl/bfe_frontend.sv
module bfe_frontend #(
    parameter int unsigned AW      = 32,
    parameter int unsigned IW      = 32,
    parameter int unsigned OFFW    = 16,
    parameter int unsigned BR_BIT  = 31,
    parameter int unsigned UNC_BIT = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] imem_addr,
    input  logic [IW-1:0] imem_rdata,
    input  logic          ex_cond_taken,
    output logic          id_valid,
    output logic [IW-1:0] id_instr,
    output logic [AW-1:0] id_npc,
    output logic          ex_valid,
    output logic [IW-1:0] ex_instr,
    output logic [AW-1:0] ex_npc,
    output logic [AW-1:0] ex_target,
    output logic          ex_is_cond,
    output logic          ex_pred_taken,
    output logic          ex_mispredict
);
    import bfe_pkg::*;

    localparam logic [AW-1:0] INC = AW'(INSTR_BYTES);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          ifid_valid;
        logic [IW-1:0] ifid_instr;
        logic [AW-1:0] ifid_npc;
        logic          idex_valid;
        logic [IW-1:0] idex_instr;
        logic [AW-1:0] idex_npc;
        logic [AW-1:0] idex_target;
        logic          idex_cond;
        logic          idex_pred;
    } fe_state_t;

    fe_state_t st_d, st_q;

    logic          id_is_cond, id_redirect;
    logic [AW-1:0] id_target;
    logic          mis;
    logic [AW-1:0] fix_pc;
    logic [AW-1:0] pc_next;
    logic          kill_if, kill_id;
    logic [AW-1:0] seq_pc;

    assign seq_pc = st_q.pc + INC;

    bfe_predecode #(.AW(AW), .OFFW(OFFW)) u_predecode (
        .slot_valid (st_q.ifid_valid),
        .br_flag    (st_q.ifid_instr[BR_BIT]),
        .unc_flag   (st_q.ifid_instr[UNC_BIT]),
        .offset     (st_q.ifid_instr[OFFW-1:0]),
        .npc        (st_q.ifid_npc),
        .is_cond    (id_is_cond),
        .redirect   (id_redirect),
        .target     (id_target)
    );

    bfe_resolve #(.AW(AW)) u_resolve (
        .slot_valid (st_q.idex_valid),
        .is_cond    (st_q.idex_cond),
        .pred_taken (st_q.idex_pred),
        .cond_taken (ex_cond_taken),
        .target     (st_q.idex_target),
        .npc        (st_q.idex_npc),
        .mispredict (mis),
        .fix_pc     (fix_pc)
    );

    bfe_pcsel #(.AW(AW)) u_pcsel (
        .seq_pc      (seq_pc),
        .id_redirect (id_redirect),
        .id_target   (id_target),
        .ex_restart  (mis),
        .ex_pc       (fix_pc),
        .pc_next     (pc_next),
        .kill_if     (kill_if),
        .kill_id     (kill_id)
    );

    always_comb begin
        st_d             = st_q;
        st_d.pc          = pc_next;
        st_d.ifid_valid  = !kill_if;
        st_d.ifid_instr  = imem_rdata;
        st_d.ifid_npc    = seq_pc;
        st_d.idex_valid  = st_q.ifid_valid && !kill_id;
        st_d.idex_instr  = st_q.ifid_instr;
        st_d.idex_npc    = st_q.ifid_npc;
        st_d.idex_target = id_target;
        st_d.idex_cond   = id_is_cond && !kill_id;
        st_d.idex_pred   = id_redirect;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q            <= '0;
        end else begin
            st_q            <= st_d;
        end
    end

    assign imem_addr     = st_q.pc;
    assign id_valid      = st_q.ifid_valid;
    assign id_instr      = st_q.ifid_instr;
    assign id_npc        = st_q.ifid_npc;
    assign ex_valid      = st_q.idex_valid;
    assign ex_instr      = st_q.idex_instr;
    assign ex_npc        = st_q.idex_npc;
    assign ex_target     = st_q.idex_target;
    assign ex_is_cond    = st_q.idex_cond;
    assign ex_pred_taken = st_q.idex_pred;
    assign ex_mispredict = mis;

    // R8
    mispredict_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_mispredict |=> (!id_valid && !ex_valid));

    // R10
    restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_mispredict |=> (imem_addr == $past(fix_pc)));

    // R5
    id_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_redirect && !ex_mispredict) |=> (!id_valid && imem_addr == $past(id_target)));

    // R2
    seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_redirect && !ex_mispredict) |=> (imem_addr == $past(imem_addr) + INC));

    // R7
    uncond_no_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_instr[BR_BIT] && ex_instr[UNC_BIT]) |-> !ex_mispredict);
endmodule

// File: tb/tb_bfe_frontend.sv
module tb_bfe_frontend;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BR = 32'h40;

    typedef struct packed {
        logic [31:0] i1;
        logic [31:0] i2;
        logic        taken;
        logic [31:0] a2;
        logic        idv2;
        logic        mis;
        logic [31:0] a3;
        logic [31:0] tgt;
    } vec_t;

    // cond = 10xx, uncond = 11xx, offset in [15:0]
    localparam vec_t VEC [9] = '{
        '{32'h8000_FFF8, 32'h0, 1'b1, 32'h24,       1'b0, 1'b0, 32'h28,       32'h24},
        '{32'h8000_FFF8, 32'h0, 1'b0, 32'h24,       1'b0, 1'b1, 32'h44,       32'h24},
        '{32'h8000_0004, 32'h0, 1'b0, 32'h48,       1'b1, 1'b0, 32'h4C,       32'h54},
        '{32'h8000_0004, 32'h0, 1'b1, 32'h48,       1'b1, 1'b1, 32'h54,       32'h54},
        '{32'hC000_0004, 32'h0, 1'b0, 32'h54,       1'b0, 1'b0, 32'h58,       32'h54},
        '{32'hC000_FFF8, 32'h0, 1'b1, 32'h24,       1'b0, 1'b0, 32'h28,       32'h24},
        '{32'h8000_0004, 32'hC000_0008, 1'b1, 32'h48, 1'b1, 1'b1, 32'h54,     32'h54},
        '{32'h8000_8000, 32'h0, 1'b1, 32'hFFFE_0044, 1'b0, 1'b0, 32'hFFFE_0048, 32'hFFFE_0044},
        '{32'h8000_7FFF, 32'h0, 1'b0, 32'h48,       1'b1, 1'b0, 32'h4C,       32'h0002_0040}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata;
    logic        ex_cond_taken = 1'b0;
    logic        id_valid, ex_valid, ex_is_cond, ex_pred_taken, ex_mispredict;
    logic [31:0] id_instr, id_npc, ex_instr, ex_npc, ex_target;
    logic [31:0] cur_i1 = 32'h0, cur_i2 = 32'h0;
    int          n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: branch words at BR and BR+4 when set, else tagged non-branch words
    always_comb begin
        if (imem_addr == BR && cur_i1 != 32'h0)             imem_rdata = cur_i1;
        else if (imem_addr == BR + 32'h4 && cur_i2 != 32'h0) imem_rdata = cur_i2;
        else imem_rdata = {16'h0013, imem_addr[15:0]};
    end

    bfe_frontend dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .ex_cond_taken(ex_cond_taken), .id_valid(id_valid), .id_instr(id_instr),
        .id_npc(id_npc), .ex_valid(ex_valid), .ex_instr(ex_instr), .ex_npc(ex_npc),
        .ex_target(ex_target), .ex_is_cond(ex_is_cond), .ex_pred_taken(ex_pred_taken),
        .ex_mispredict(ex_mispredict)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 addr in reset", imem_addr, 32'h0);
        check("R1 id_valid in reset", {31'h0, id_valid}, 32'h0);
        check("R1 ex_valid in reset", {31'h0, ex_valid}, 32'h0);
        check("R1 mispredict in reset", {31'h0, ex_mispredict}, 32'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1 and R2: reset state and plain sequential fetch
        cur_i1 = 32'h0; cur_i2 = 32'h0;
        do_reset();
        check("R1 first addr after release", imem_addr, 32'h0);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            check("R2 sequential addr", imem_addr, 32'(4 * k));
            check("R2 id_npc", id_npc, 32'(4 * k));
            check("R2 id_instr", id_instr, {16'h0013, 16'(4 * (k - 1))});
            check("R4 non-branch stays valid", {31'h0, id_valid}, 32'h1);
        end

        // vector walk: one branch at BR, observed for three cycles
        for (int v = 0; v < 9; v++) begin
            rst_n = 1'b0;
            cur_i1 = VEC[v].i1;
            cur_i2 = VEC[v].i2;
            ex_cond_taken = VEC[v].taken;
            do_reset();
            for (int w = 0; w < 64 && imem_addr != BR; w++) @(negedge clk);
            @(negedge clk);
            check("R2 fall-through fetched", imem_addr, BR + 32'h4);
            check("R2 npc of branch", id_npc, BR + 32'h4);
            @(negedge clk);
            check("R5/R6/R7 addr after decode", imem_addr, VEC[v].a2);
            check("R5/R6 decode slot bubble", {31'h0, id_valid}, {31'h0, VEC[v].idv2});
            check("R8/R9/R7 mispredict flag", {31'h0, ex_mispredict}, {31'h0, VEC[v].mis});
            check("R3 target", ex_target, VEC[v].tgt);
            check("R3 ex_npc", ex_npc, BR + 32'h4);
            @(negedge clk);
            check("R8/R9/R10 restart addr", imem_addr, VEC[v].a3);
            if (VEC[v].mis) begin
                check("R8 flush id", {31'h0, id_valid}, 32'h0);
                check("R8 flush ex", {31'h0, ex_valid}, 32'h0);
            end
        end

        // R1: reset mid-flight clears slots with a branch in the pipe
        rst_n = 1'b0;
        cur_i1 = 32'h8000_0004; cur_i2 = 32'h0; ex_cond_taken = 1'b1;
        do_reset();
        for (int w = 0; w < 64 && imem_addr != BR; w++) @(negedge clk);
        @(negedge clk);
        do_reset();
        check("R1 addr restarts at zero", imem_addr, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule